// File: doc/BRIEF.md
# Late-Redirect Branch Squash Controller

This block resolves control hazards for a five-stage in-order pipeline in which a taken control transfer changes the program counter only once it reaches the memory-access stage. It owns the fetch program counter. It picks each cycle's next fetch address from three sources: the current address held, the sequential step of one instruction width, or the redirect target carried down the pipe with the control-transfer instruction.

Redirect resolves late, so three younger instructions are already in flight when it fires. These are the ones in fetch, decode and execute. Stalling cannot save them, because they are already on the wrong path. On a redirect the block therefore raises three squash strobes. Each strobe makes a pipeline register load a bubble at the next clock edge. The squash strobes are:

- `flush_fd` for the fetch/decode register.
- `flush_de` for the decode/execute register.
- `flush_em` for the execute/memory register.

A redirect overrides a concurrent stall request from the data interlock, because that stall comes from an instruction that is being squashed. While reset is active, and for the first cycle after it is released, all three strobes are held high so that every stage starts empty.

Top module: `branch_squash_ctl`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals RESET_PC (default 32'h0000_1000) asynchronously, and `flush_fd`, `flush_de` and `flush_em` are all 1.
- R2: In the cycle between reset release and the first rising clock edge, all three flush outputs stay 1 and `next_pc` equals RESET_PC. After that edge `fetch_pc` is still RESET_PC and the flush outputs drop to 0.
- R3: When no redirect or stall is present, `next_pc` is `fetch_pc + 4`, no flush or hold is raised, and `fetch_pc` takes that value at the next rising edge.
- R4: A redirect occurs when `ma_valid`, `ma_cti` and `ma_taken` are all 1. In that same cycle all three flush outputs are 1 and `next_pc` is the target. At the next edge `fetch_pc` becomes the target.
- R5: A control transfer that is not taken (`ma_valid`=1, `ma_cti`=1, `ma_taken`=0) raises no flush, and fetch continues at `fetch_pc + 4`.
- R6: When `ma_valid` is 0, the values of `ma_cti`, `ma_taken` and `ma_target` have no effect on any output.
- R7: When `stall_req` is 1 and there is no redirect, `fetch_hold` is 1, `next_pc` equals `fetch_pc`, no flush is raised, and `fetch_pc` is unchanged after the edge.
- R8: A redirect takes priority over `stall_req`. `fetch_hold` is 0 and `next_pc` is the target.
- R9: The redirect target is aligned to the instruction width by clearing its two low bits, so `fetch_pc[1:0]` is always 0.
- R10: The sequential step wraps modulo 2^32, so 32'hFFFF_FFFC is followed by 32'h0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_valid | input | 1 | Memory-access stage holds a live instruction |
| ma_cti | input | 1 | That instruction is a control transfer |
| ma_taken | input | 1 | The control transfer changes the PC |
| ma_target | input | 32 | Redirect address carried with the instruction |
| stall_req | input | 1 | Fetch stall requested by the data interlock |
| fetch_pc | output | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Address to fetch in the next cycle |
| fetch_hold | output | 1 | Fetch and fetch/decode register must hold |
| flush_fd | output | 1 | Fetch/decode register loads a bubble |
| flush_de | output | 1 | Decode/execute register loads a bubble |
| flush_em | output | 1 | Execute/memory register loads a bubble |

## Verification
`next_pc`, `fetch_hold` and the three flush outputs are combinational functions of the inputs and `fetch_pc`, so they are due in the same cycle as the stimulus. `fetch_pc` passes through one register and is due one rising edge later. The bench drives inputs on the falling edge and reads the combinational results 1 ns later. It then waits for the rising edge and reads `fetch_pc` 1 ns after that edge, comparing it with a program counter kept by the bench itself. Every combination of the four control inputs is swept twice with different targets. Separate cases cover reset entry and release, an asynchronous reset in mid-run, and wraparound at the top of the address space.

// File: rtl/crh_pkg.sv
package crh_pkg;

  // Source of the next fetch address
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_SEQ  = 2'd1,
    PC_JUMP = 2'd2
  } pc_src_e;

  // Squash strobes, one per younger pipeline register
  typedef struct packed {
    logic fd;
    logic de;
    logic em;
  } squash_t;

endpackage

// File: rtl/crh_select.sv
module crh_select
  import crh_pkg::*;
(
  input  logic    ready,
  input  logic    ma_valid,
  input  logic    ma_cti,
  input  logic    ma_taken,
  input  logic    stall_req,
  output pc_src_e src,
  output squash_t kill,
  output logic    hold
);

  logic redirect;

  always_comb begin
    redirect = ma_valid & ma_cti & ma_taken;
    src      = PC_SEQ;
    kill     = squash_t'(3'b000);
    hold     = 1'b0;
    if (!ready) begin
      // pipeline still being emptied after reset
      src  = PC_HOLD;
      kill = squash_t'(3'b111);
    end else if (redirect) begin
      // late redirect: three younger instructions are wrong-path
      src  = PC_JUMP;
      kill = squash_t'(3'b111);
    end else if (stall_req) begin
      src  = PC_HOLD;
      hold = 1'b1;
    end
  end

endmodule

// File: rtl/crh_pc.sv
module crh_pc
  import crh_pkg::*;
#(
  parameter int unsigned        XLEN        = 32,
  parameter int unsigned        INSTR_BYTES = 4,
  parameter logic [XLEN-1:0]    RESET_PC    = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_src_e         src,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_d
);

  localparam logic [XLEN-1:0] STEP       = XLEN'(INSTR_BYTES);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(INSTR_BYTES - 1));

  logic pc_en;

  always_comb begin
    unique case (src)
      PC_JUMP: pc_d = target & ALIGN_MASK;
      PC_SEQ:  pc_d = pc_q + STEP;
      default: pc_d = pc_q;
    endcase
    pc_en = (src != PC_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/branch_squash_ctl.sv
module branch_squash_ctl
  import crh_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC    = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ma_valid,
  input  logic            ma_cti,
  input  logic            ma_taken,
  input  logic [XLEN-1:0] ma_target,
  input  logic            stall_req,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            fetch_hold,
  output logic            flush_fd,
  output logic            flush_de,
  output logic            flush_em
);

  localparam int unsigned ALIGN_BITS = $clog2(INSTR_BYTES);

  logic    ready_q, ready_d;
  pc_src_e src;
  squash_t kill;
  logic    br_taken_ma;

  // ready drops asynchronously, rises on the first edge after release
  always_comb ready_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  crh_select u_sel (
    .ready     (ready_q),
    .ma_valid  (ma_valid),
    .ma_cti    (ma_cti),
    .ma_taken  (ma_taken),
    .stall_req (stall_req),
    .src       (src),
    .kill      (kill),
    .hold      (fetch_hold)
  );

  crh_pc #(
    .XLEN        (XLEN),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_PC    (RESET_PC)
  ) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src),
    .target (ma_target),
    .pc_q   (fetch_pc),
    .pc_d   (next_pc)
  );

  always_comb begin
    flush_fd    = kill.fd;
    flush_de    = kill.de;
    flush_em    = kill.em;
    br_taken_ma = ma_valid & ma_cti & ma_taken;
  end

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !br_taken_ma && !stall_req) |=> fetch_pc == $past(fetch_pc) + XLEN'(INSTR_BYTES));

  // R4
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_ma |-> (flush_fd && flush_de && flush_em));

  // R4
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && br_taken_ma) |=>
      fetch_pc[XLEN-1:ALIGN_BITS] == $past(ma_target[XLEN-1:ALIGN_BITS]));

  // R5
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && ma_valid && ma_cti && !ma_taken) |-> !(flush_fd || flush_de || flush_em));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && stall_req && !br_taken_ma) |=> $stable(fetch_pc));

  // R8
  redirect_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_ma |-> !fetch_hold);

  // R9
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pc[ALIGN_BITS-1:0] == '0);

endmodule

// File: tb/branch_squash_ctl_test.sv
module branch_squash_ctl_test;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ma_valid, ma_cti, ma_taken, stall_req;
  logic [31:0] ma_target;
  logic [31:0] fetch_pc, next_pc;
  logic        fetch_hold, flush_fd, flush_de, flush_em;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  branch_squash_ctl uut (
    .clk(clk), .rst_n(rst_n), .ma_valid(ma_valid), .ma_cti(ma_cti),
    .ma_taken(ma_taken), .ma_target(ma_target), .stall_req(stall_req),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .fetch_hold(fetch_hold),
    .flush_fd(flush_fd), .flush_de(flush_de), .flush_em(flush_em)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] flushes();
    return {29'b0, flush_fd, flush_de, flush_em};
  endfunction

  task automatic apply(input logic v, input logic c, input logic t,
                       input logic s, input logic [31:0] tgt);
    logic        redir;
    logic [31:0] exp_next;
    string       tag;
    @(negedge clk);
    ma_valid = v; ma_cti = c; ma_taken = t; stall_req = s; ma_target = tgt;
    #1;
    redir    = v & c & t;
    exp_next = redir ? (tgt & 32'hFFFF_FFFC) : (s ? model_pc : model_pc + 32'd4);
    if (redir && s)          tag = "R8";
    else if (redir)          tag = "R4 R9";
    else if (!v && (c || t)) tag = "R6";
    else if (v && c && !t)   tag = "R5";
    else if (s)              tag = "R7";
    else                     tag = "R3";
    check(tag, "next_pc", next_pc, exp_next);
    check(tag, "hold", {31'b0, fetch_hold}, {31'b0, (!redir && s)});
    check(tag, "flush", flushes(), redir ? 32'd7 : 32'd0);
    @(posedge clk);
    #1;
    model_pc = exp_next;
    check(tag, "fetch_pc", fetch_pc, model_pc);
  endtask

  initial begin
    rst_n = 1'b0;
    ma_valid = 0; ma_cti = 0; ma_taken = 0; stall_req = 0; ma_target = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fetch_pc", fetch_pc, RST_PC);
    check("R1", "flush", flushes(), 32'd7);
    // R2: release, one cycle of emptying
    rst_n = 1'b1;
    #1;
    check("R2", "flush", flushes(), 32'd7);
    check("R2", "next_pc", next_pc, RST_PC);
    @(posedge clk);
    #1;
    check("R2", "fetch_pc", fetch_pc, RST_PC);
    check("R2", "flush", flushes(), 32'd0);
    model_pc = RST_PC;

    // exhaustive sweep of the four control inputs, two target patterns
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 16; i++) begin
        apply(i[3], i[2], i[1], i[0],
              32'h0000_2000 + 32'(i) * 32'h44 + 32'(k) * 32'h0001_0003);
      end
    end

    // R9 and R10: unaligned target at the top, then wrap
    apply(1, 1, 1, 0, 32'hFFFF_FFFE);
    check("R9", "low bits", {30'b0, fetch_pc[1:0]}, 32'd0);
    apply(0, 0, 0, 0, 32'h0);
    check("R10", "wrapped pc", fetch_pc, 32'h0000_0000);
    apply(0, 0, 0, 0, 32'h0);

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R1", "async fetch_pc", fetch_pc, RST_PC);
    check("R1", "async flush", flushes(), 32'd7);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    model_pc = RST_PC;
    check("R2", "fetch_pc after re-reset", fetch_pc, RST_PC);
    apply(0, 0, 0, 0, 32'h0);
    apply(1, 1, 1, 1, 32'h0000_3001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule